// File: doc/BRIEF.md
# Clock Manager Status Monitor

This block produces the lock indication and an eight-bit status word for a clock manager. A free-running monitor clock samples two monitored clocks: the input reference clock and the synthesized output clock. Each sample goes through a synchroniser chain. The block then counts how many monitor cycles pass without a transition. A clock that stays quiet for a parameterised number of cycles (default 16) is reported as stopped. Its flag clears again shortly after transitions resume.

The two stopped flags sit at fixed positions in the status word. A strap input gates each flag. The reference flag shows only when the feedback path is connected. The synthesized flag shows only when that output is actually in use. All other status bits read zero.

The lock output follows the lock-achieved indication from the phase alignment logic. It drops in the same monitor cycle in which the reference clock is judged stopped. An asynchronous active-high reset forces every output and all internal state back to the power-on condition.

Top module: `clkmgr_status_mon`

## Requirements
- R1: While `rst` is high, `locked` is 0 and `status` is 8'h00, independent of any clock edge. After reset all stopped conditions start cleared.
- R2: While the reference clock toggles, `locked` takes the value `phase_lock_in` had at the previous rising edge of `mon_clk`, so it trails that input by one monitor cycle.
- R3: `locked` is 0 in every cycle in which the internal reference-stopped condition is true, including the very cycle it first asserts.
- R4: With `fb_connected` = 1, `status[1]` is 1 once the reference clock has shown no transition for STOP_CYCLES (default 16) monitor cycles. It is 0 while the reference toggles with a half period of at most STOP_CYCLES/2 monitor cycles.
- R5: With `fb_connected` = 0, `status[1]` stays 0 even when the reference clock has stopped.
- R6: With `synth_used` = 1, `status[2]` is 1 once the synthesized clock has been quiet for STOP_CYCLES monitor cycles, and 0 while it toggles.
- R7: With `synth_used` = 0, `status[2]` stays 0 even when the synthesized clock has stopped.
- R8: A stopped flag clears no later than SYNC_STAGES+2 monitor cycles after the first transition of the resumed clock.
- R9: Status bits 0, 3, 4, 5, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock |
| rst | input | 1 | Asynchronous active-high reset |
| ref_clk | input | 1 | Input reference clock under watch |
| synth_clk | input | 1 | Synthesized output clock under watch |
| fb_connected | input | 1 | Strap: feedback path is connected |
| synth_used | input | 1 | Strap: synthesized output is in use |
| phase_lock_in | input | 1 | Lock-achieved indication from phase alignment |
| locked | output | 1 | Lock indication |
| status | output | 8 | Status word: bit 1 reference stopped, bit 2 synthesized stopped |

## Verification
The reference-stopped flag and the lock drop are driven by the same detector event. Both can therefore change in one monitor cycle. The bench provokes this by holding `phase_lock_in` high, feeding the feedback strap, and stopping the reference clock at random half periods. On every falling monitor edge it checks that `locked` and `status[1]` are never high together. After each settle it compares both outputs against values computed from the bench's own knowledge of which clocks run.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
   localparam int STATUS_W       = 8;
   localparam int REF_STOP_BIT   = 1;
   localparam int SYNTH_STOP_BIT = 2;
   typedef logic [STATUS_W-1:0] status_t;
endpackage

// File: rtl/clkmon_activity.sv
module clkmon_activity #(
   parameter int SYNC_STAGES = 2,
   parameter int STOP_CYCLES = 16
) (
   input  logic mon_clk,
   input  logic rst,
   input  logic watched,
   output logic stopped
);
   localparam int CW = $clog2(STOP_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT   = CW'(STOP_CYCLES);
   localparam logic [CW-1:0] NEAR    = CW'(STOP_CYCLES - 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clkmon_activity: SYNC_STAGES must be at least 2");
      end
      if (STOP_CYCLES < 2) begin : g_bad_stop
         $error("clkmon_activity: STOP_CYCLES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] chain;
   logic                   last_q;
   logic                   edge_seen;
   logic [CW-1:0]          quiet_cnt;

   generate
      genvar gi;
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge mon_clk or posedge rst) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= watched;
            end
         end else begin : g_next
            always_ff @(posedge mon_clk or posedge rst) begin
               if (rst) chain[gi] <= 1'b0;
               else     chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge mon_clk or posedge rst) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= chain[SYNC_STAGES-1];
   end

   assign edge_seen = chain[SYNC_STAGES-1] ^ last_q;

   always_ff @(posedge mon_clk or posedge rst) begin
      if (rst) begin
         quiet_cnt <= '0;
      end else if (edge_seen) begin
         quiet_cnt <= '0;
      end else if (quiet_cnt != LIMIT) begin
         quiet_cnt <= quiet_cnt + 1'b1;
      end
   end

   always_ff @(posedge mon_clk or posedge rst) begin
      if (rst) stopped <= 1'b0;
      else     stopped <= !edge_seen && (quiet_cnt >= NEAR);
   end

   // R8: a fresh transition removes the stopped flag on the next cycle
   p_edge_clears_r8: assert property (@(posedge mon_clk) disable iff (rst)
      edge_seen |=> !stopped);

   // R4: the quiet counter never runs past its limit
   p_cnt_bound_r4: assert property (@(posedge mon_clk) disable iff (rst)
      quiet_cnt <= LIMIT);

   // R4: the flag rises only after a quiet cycle
   p_rise_quiet_r4: assert property (@(posedge mon_clk) disable iff (rst)
      $rose(stopped) |-> $past(!edge_seen));
endmodule

// File: rtl/clkmon_lock.sv
module clkmon_lock #(
   parameter bit LOCK_REG = 1'b1
) (
   input  logic mon_clk,
   input  logic rst,
   input  logic lock_req,
   input  logic ref_stop,
   output logic locked
);
   logic lock_q;

   generate
      if (LOCK_REG) begin : g_reg
         always_ff @(posedge mon_clk or posedge rst) begin
            if (rst) lock_q <= 1'b0;
            else     lock_q <= lock_req;
         end
      end else begin : g_pass
         assign lock_q = lock_req & ~rst;
      end
   endgenerate

   assign locked = lock_q & ~ref_stop & ~rst;

   // R3: no lock indication while the reference is judged stopped
   p_lock_drop_r3: assert property (@(posedge mon_clk) disable iff (rst)
      ref_stop |-> !locked);

   // R2: a rising lock always stems from a lock request
   p_lock_follow_r2: assert property (@(posedge mon_clk) disable iff (rst)
      $rose(locked) && !$past(ref_stop) |-> $past(lock_req) || !LOCK_REG);
endmodule

// File: rtl/clkmon_status_pack.sv
module clkmon_status_pack
   import clkmon_pkg::*;
(
   input  logic    mon_clk,
   input  logic    rst,
   input  logic    ref_stop,
   input  logic    synth_stop,
   input  logic    fb_connected,
   input  logic    synth_used,
   output status_t status
);
   always_comb begin
      status                 = '0;
      status[REF_STOP_BIT]   = ref_stop & fb_connected & ~rst;
      status[SYNTH_STOP_BIT] = synth_stop & synth_used & ~rst;
   end

   // R5: reference flag gated by the feedback strap
   p_fb_gate_r5: assert property (@(posedge mon_clk) disable iff (rst)
      !fb_connected |-> !status[REF_STOP_BIT]);

   // R7: synthesized flag gated by the output-in-use strap
   p_synth_gate_r7: assert property (@(posedge mon_clk) disable iff (rst)
      !synth_used |-> !status[SYNTH_STOP_BIT]);

   // R6: an in-use stopped synthesized clock is reported
   p_synth_show_r6: assert property (@(posedge mon_clk) disable iff (rst)
      synth_used && synth_stop |-> status[SYNTH_STOP_BIT]);
endmodule

// File: rtl/clkmgr_status_mon.sv
module clkmgr_status_mon
   import clkmon_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STOP_CYCLES = 16,
   parameter bit LOCK_REG    = 1'b1
) (
   input  logic                mon_clk,
   input  logic                rst,
   input  logic                ref_clk,
   input  logic                synth_clk,
   input  logic                fb_connected,
   input  logic                synth_used,
   input  logic                phase_lock_in,
   output logic                locked,
   output logic [STATUS_W-1:0] status
);
   logic ref_stop;
   logic synth_stop;

   clkmon_activity #(.SYNC_STAGES(SYNC_STAGES), .STOP_CYCLES(STOP_CYCLES)) u_ref_act (
      .mon_clk (mon_clk),
      .rst     (rst),
      .watched (ref_clk),
      .stopped (ref_stop)
   );

   clkmon_activity #(.SYNC_STAGES(SYNC_STAGES), .STOP_CYCLES(STOP_CYCLES)) u_synth_act (
      .mon_clk (mon_clk),
      .rst     (rst),
      .watched (synth_clk),
      .stopped (synth_stop)
   );

   clkmon_lock #(.LOCK_REG(LOCK_REG)) u_lock (
      .mon_clk  (mon_clk),
      .rst      (rst),
      .lock_req (phase_lock_in),
      .ref_stop (ref_stop),
      .locked   (locked)
   );

   clkmon_status_pack u_pack (
      .mon_clk      (mon_clk),
      .rst          (rst),
      .ref_stop     (ref_stop),
      .synth_stop   (synth_stop),
      .fb_connected (fb_connected),
      .synth_used   (synth_used),
      .status       (status)
   );

   // R1: reset forces outputs quiet
   always_comb begin
      if (rst) p_reset_quiet_r1: assert (!locked && status == '0);
   end

   // R4: a reported reference stop never coincides with lock
   p_flag_vs_lock_r4: assert property (@(posedge mon_clk) disable iff (rst)
      status[REF_STOP_BIT] |-> !locked);
endmodule

// File: tb/clkmgr_status_mon_test.sv
`timescale 1ns/1ps
module clkmgr_status_mon_test;
   localparam int SYNC = 2;
   localparam int STOP = 16;

   logic mon_clk = 1'b0;
   logic rst = 1'b1;
   logic ref_clk = 1'b0, synth_clk = 1'b0;
   logic fb_connected = 1'b1, synth_used = 1'b1, phase_lock_in = 1'b0;
   logic locked;
   logic [7:0] status;

   logic ref_run = 1'b1, synth_run = 1'b1;
   int   ref_half = 13, synth_half = 17;
   int   checks = 0, errors = 0;
   bit   inv_on = 1'b0;

   clkmgr_status_mon #(.SYNC_STAGES(SYNC), .STOP_CYCLES(STOP)) uut (
      .mon_clk(mon_clk), .rst(rst), .ref_clk(ref_clk), .synth_clk(synth_clk),
      .fb_connected(fb_connected), .synth_used(synth_used),
      .phase_lock_in(phase_lock_in), .locked(locked), .status(status));

   always #5 mon_clk = ~mon_clk;

   initial forever begin
      if (ref_run) begin #(ref_half); if (ref_run) ref_clk = ~ref_clk; end
      else #1;
   end
   initial forever begin
      if (synth_run) begin #(synth_half); if (synth_run) synth_clk = ~synth_clk; end
      else #1;
   end

   function automatic logic [7:0] exp_status(bit ref_dead, bit syn_dead, bit fb, bit su);
      logic [7:0] s = 8'h00;
      s[1] = ref_dead & fb;
      s[2] = syn_dead & su;
      return s;
   endfunction

   function automatic bit exp_locked(bit lock_in, bit ref_dead);
      return lock_in & ~ref_dead;
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) @(negedge mon_clk);
   endtask

   // R3 and R9 checked every cycle: lock never with reference flag, reserved zero
   always @(negedge mon_clk) begin
      if (inv_on && !rst) begin
         chk("R3", {7'd0, locked & status[1]}, 8'h00);
         chk("R9", status & 8'b1111_1001, 8'h00);
      end
   end

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      // R1: reset state
      cyc(3);
      chk("R1 locked", {7'd0, locked}, 8'h00);
      chk("R1 status", status, 8'h00);
      rst = 1'b0;
      inv_on = 1'b1;
      cyc(STOP + 10);
      chk("R4 running", status, 8'h00);

      // R2: lock follows one monitor cycle later
      phase_lock_in = 1'b1;
      chk("R2 before", {7'd0, locked}, 8'h00);
      cyc(1);
      chk("R2 after", {7'd0, locked}, 8'h01);
      phase_lock_in = 1'b0;
      cyc(1);
      chk("R2 drop", {7'd0, locked}, 8'h00);
      phase_lock_in = 1'b1;
      cyc(2);

      // R4: not flagged early, flagged after the quiet window; R3 lock drops
      ref_run = 1'b0;
      cyc(STOP / 2);
      chk("R4 early", status, 8'h00);
      chk("R3 early lock", {7'd0, locked}, 8'h01);
      cyc(STOP + SYNC + 8);
      chk("R4 stopped", status, 8'h02);
      chk("R3 lock", {7'd0, locked}, 8'h00);

      // R1: asynchronous reset in the middle of a stop
      #2 rst = 1'b1;
      #1 chk("R1 async", {status[7:1], locked}, 8'h00);
      cyc(2);
      rst = 1'b0;
      cyc(1);
      chk("R1 cleared", status, 8'h00);
      cyc(STOP + SYNC + 8);
      chk("R4 again", status, 8'h02);

      // R8: flag clears soon after resume
      ref_run = 1'b1;
      cyc(4 + SYNC + 4);
      chk("R8 clear", status, 8'h00);
      chk("R8 lock back", {7'd0, locked}, 8'h01);

      // R5: no feedback strap hides the reference flag, lock still drops
      fb_connected = 1'b0;
      ref_run = 1'b0;
      cyc(STOP + SYNC + 8);
      chk("R5 gated", status, 8'h00);
      chk("R3 ungated lock", {7'd0, locked}, 8'h00);
      ref_run = 1'b1;
      fb_connected = 1'b1;
      cyc(12);

      // R6, R7: synthesized clock flag and its gating
      synth_run = 1'b0;
      cyc(STOP + SYNC + 8);
      chk("R6 shown", status, 8'h04);
      synth_used = 1'b0;
      cyc(1);
      chk("R7 gated", status, 8'h00);
      synth_used = 1'b1;
      synth_run = 1'b1;
      cyc(4 + SYNC + 4);
      chk("R8 synth clear", status, 8'h00);

      // random mix: R2 R3 R4 R5 R6 R7
      for (int it = 0; it < 40; it++) begin
         fb_connected  = 1'($urandom_range(0, 1));
         synth_used    = 1'($urandom_range(0, 1));
         phase_lock_in = 1'($urandom_range(0, 1));
         ref_half      = $urandom_range(11, 38);
         synth_half    = $urandom_range(11, 38);
         ref_run       = 1'($urandom_range(0, 1));
         synth_run     = 1'($urandom_range(0, 1));
         cyc(STOP + SYNC + 12);
         chk("R4-R7 random status", status,
             exp_status(!ref_run, !synth_run, fb_connected, synth_used));
         chk("R2 R3 random lock", {7'd0, locked},
             {7'd0, exp_locked(phase_lock_in, !ref_run)});
      end

      inv_on = 1'b0;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule